// File: doc/BRIEF.md
# Chipset Power State Sequencer

This block steps an application-processor platform through four power levels: off (G3), soft-off (S5), suspend (S3) and run (S0). Every move between levels passes through a named transition state. In those states the block drives four active-low pins in a fixed order, with a delay after each step. The pins are the PMIC enable, the PMIC force-reset, the PMIC watchdog and the processor system reset. All delays are counted in ticks of a one-millisecond strobe by one shared down-counter, so a system clock of any speed can be used. Every delay is a parameter, which lets a small configuration be simulated quickly.

The block watches PMIC power-good, a suspend indicator from the processor, and single-cycle pulses that request a forced shutdown or a power-on. It also watches a charger-ready flag and a low-battery flag. To bring the rails up it pulses the PMIC enable, and it retries once if power-good does not arrive. To force the PMIC off it first holds the enable low like a long button press, and then uses a timed force-reset. It also filters the processor's watchdog line: a falling edge counts as a reset request only while power-good is present and while the processor is out of reset. All control and status pins are plain levels or strobes; no data streams through the block.

Top module: `pwr_state_seq`

## Requirements
- R1: Under reset the state is S5 when `pgood` is high and G3 when it is low. `pmic_en_n`, `pmic_force_rst_n` and `pmic_wdog_n` are high, and `ap_rst_n` is low. `state_o` codes are: G3=0, S5=1, S3=2, S0=3, G3S5=4, S5S3=5, S3S0=6, S0S3=7, S3S5=8, S5G3=9. No other value ever appears.
- R2: On entry to S5S3 the enable is released. If `pgood` is low, the block waits PULSE_MS ticks, drives `pmic_en_n` low for PULSE_MS ticks and then releases it.
- R3: After the pulse the block waits up to PG_TIMEOUT_MS ticks for `pgood`. The first timeout restarts the S5S3 attempt, so a second pulse follows. The second timeout moves to S5G3, which goes on to G3 when `pgood` is low.
- R4: Once `pgood` is seen, `pmic_wdog_n` goes high first. Then `ap_rst_n` goes high and is held RST_HOLD_MS ticks before S3 is entered. `ap_rst_n` is never high while `pmic_wdog_n` is low.
- R5: S3 moves to S3S5 on a `pgood` loss or a pending forced shutdown. Otherwise it moves to S3S0 when `ap_suspend` is low. S0 is entered only from S3S0. S0 leaves through S0S3 when `pgood` is low, a forced shutdown is pending, or `ap_suspend` is high.
- R6: S3S5 first drives `ap_rst_n` low, then drives `pmic_wdog_n` low and holds it WDOG_HOLD_MS ticks before entering S5. If `pgood` was already low on entry to S3S5, S5 moves straight to S5G3 without starting a new power-up.
- R7: In S5, when a forced shutdown is pending and `pgood` is high, `pmic_en_n` is held low and the state stays S5. When `pgood` falls, the block goes through S5G3, where the enable is released, and on to G3.
- R8: In S5G3 with `pgood` high, `pmic_force_rst_n` is driven low for FORCE_RST_MS ticks, only in that state, and then released. G3 returns to S5G3 whenever `pgood` is high.
- R9: G3S5 clears the pending forced shutdown. It then checks `charger_ready` up to POLL_TRIES+1 times, POLL_MS ticks apart. If the flag is seen with `low_batt` low, the block goes to S5. If the flag is seen with `low_batt` high, or is never seen, the block returns to G3 with a forced shutdown pending.
- R10: `wdog_reset_req` pulses for one cycle after a falling edge on `ap_wdog_n` (after SYNC_STAGES synchroniser flops), but only while the filter is armed and `pgood` is high. The filter is armed when `ap_rst_n` is released in S5S3 and disarmed at the start of S3S5.
- R11: A `power_on_req` pulse is remembered. G3 leaves for G3S5 only once such a request is pending and `pgood` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| pgood | input | 1 | PMIC power-good, synchronous to clk |
| ap_suspend | input | 1 | High while the processor asks for suspend |
| force_off_req | input | 1 | One-cycle pulse requesting a forced shutdown |
| power_on_req | input | 1 | One-cycle pulse requesting power-up from G3 |
| charger_ready | input | 1 | Charger allows power-on |
| low_batt | input | 1 | Battery too low to boot |
| ap_wdog_n | input | 1 | Processor watchdog line, asynchronous, active low |
| pmic_en_n | output | 1 | PMIC enable (button), active low |
| pmic_force_rst_n | output | 1 | PMIC force-reset, active low |
| pmic_wdog_n | output | 1 | Watchdog line to PMIC, active low |
| ap_rst_n | output | 1 | Processor system reset, active low |
| wdog_reset_req | output | 1 | One-cycle watchdog reset request |
| state_o | output | 4 | Current power state code |

## Verification
The properties assume that `pgood` is already synchronous to `clk` and that `ms_tick` pulses for one cycle at a time, with at least three clocks between pulses. The measured delays only mean something under those conditions. The stimulus changes every input on the falling clock edge and issues a tick every fourth clock. It raises and drops `pgood` the way a PMIC would respond to the enable pulse. Delay checks allow one missed tick for each timer reload, because a tick that lands on a reload edge is dropped.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [3:0] {
    ST_G3   = 4'd0,
    ST_S5   = 4'd1,
    ST_S3   = 4'd2,
    ST_S0   = 4'd3,
    ST_G3S5 = 4'd4,
    ST_S5S3 = 4'd5,
    ST_S3S0 = 4'd6,
    ST_S0S3 = 4'd7,
    ST_S3S5 = 4'd8,
    ST_S5G3 = 4'd9
  } pstate_t;

  // step index inside a transition state
  typedef enum logic [2:0] {
    PH_0, PH_1, PH_2, PH_3, PH_4, PH_5, PH_6
  } phase_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwrseq_delay.sv
module pwrseq_delay #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  // a load wins over a coincident tick
  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/pwrseq_wdog_filter.sv
module pwrseq_wdog_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_in_n,
  input  logic arm,
  input  logic pgood,
  output logic req
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[g] <= 1'b1;
        else        sync_q[g] <= wd_in_n;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[g] <= 1'b1;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      req    <= 1'b0;
    end else begin
      prev_q <= sync_q[SYNC_STAGES-1];
      req    <= arm && pgood && prev_q && !sync_q[SYNC_STAGES-1];
    end
  end

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int CW            = 14,
  parameter int PULSE_MS      = 50,
  parameter int PG_TIMEOUT_MS = 300,
  parameter int RST_HOLD_MS   = 2,
  parameter int WDOG_HOLD_MS  = 3,
  parameter int FORCE_RST_MS  = 10000,
  parameter int POLL_MS       = 100,
  parameter int POLL_TRIES    = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pgood,
  input  logic          ap_suspend,
  input  logic          force_off_req,
  input  logic          power_on_req,
  input  logic          charger_ready,
  input  logic          low_batt,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          pmic_en_n,
  output logic          pmic_force_rst_n,
  output logic          pmic_wdog_n,
  output logic          ap_rst_n,
  output logic          wd_arm,
  output logic [3:0]    state_o
);

  localparam int TRW = $clog2(POLL_TRIES + 1) < 1 ? 1 : $clog2(POLL_TRIES + 1);

  pstate_t        st_q, st_n;
  phase_t         ph_q, ph_n;
  logic           en_q, en_n, frc_q, frc_n, wdg_q, wdg_n, apr_q, apr_n, arm_q, arm_n;
  logic           forcing_q, forcing_n, retry_q, retry_n, apdown_q, apdown_n, pend_q, pend_n;
  logic [TRW-1:0] tries_q, tries_n;

  always_comb begin
    st_n      = st_q;
    ph_n      = ph_q;
    en_n      = en_q;
    frc_n     = frc_q;
    wdg_n     = wdg_q;
    apr_n     = apr_q;
    arm_n     = arm_q;
    forcing_n = forcing_q || force_off_req;
    retry_n   = retry_q;
    apdown_n  = apdown_q;
    tries_n   = tries_q;
    pend_n    = pend_q || power_on_req;
    tmr_load  = 1'b0;
    tmr_val   = '0;

    unique case (st_q)
      ST_G3: begin
        if (pgood) begin
          st_n = ST_S5G3; ph_n = PH_0;
        end else if (pend_q) begin
          pend_n = 1'b0;
          st_n = ST_G3S5; ph_n = PH_0;
        end
      end

      ST_G3S5: begin
        unique case (ph_q)
          PH_0: begin
            forcing_n = 1'b0;
            tries_n   = '0;
            ph_n      = PH_1;
          end
          PH_1: begin
            if (charger_ready) begin
              if (low_batt) begin
                forcing_n = 1'b1;
                st_n = ST_G3; ph_n = PH_0;
              end else begin
                frc_n = 1'b1;
                st_n = ST_S5; ph_n = PH_0;
              end
            end else if (tries_q == TRW'(POLL_TRIES)) begin
              forcing_n = 1'b1;
              st_n = ST_G3; ph_n = PH_0;
            end else begin
              tmr_load = 1'b1;
              tmr_val  = CW'(POLL_MS);
              tries_n  = tries_q + 1'b1;
              ph_n     = PH_2;
            end
          end
          PH_2: if (tmr_expired) ph_n = PH_1;
          default: ph_n = PH_0;
        endcase
      end

      ST_S5: begin
        if (apdown_q) begin
          apdown_n = 1'b0;
          st_n = ST_S5G3; ph_n = PH_0;
        end else if (!forcing_q) begin
          retry_n = 1'b1;
          st_n = ST_S5S3; ph_n = PH_0;
        end else if (!pgood) begin
          st_n = ST_S5G3; ph_n = PH_0;
        end else begin
          en_n = 1'b0;              // long press
        end
      end

      ST_S5S3: begin
        unique case (ph_q)
          PH_0: begin
            en_n = 1'b1;
            if (pgood) ph_n = PH_4;
            else begin
              tmr_load = 1'b1; tmr_val = CW'(PULSE_MS); ph_n = PH_1;
            end
          end
          PH_1: if (tmr_expired) begin
            en_n = 1'b0;
            tmr_load = 1'b1; tmr_val = CW'(PULSE_MS); ph_n = PH_2;
          end
          PH_2: if (tmr_expired) begin
            en_n = 1'b1;
            tmr_load = 1'b1; tmr_val = CW'(PG_TIMEOUT_MS); ph_n = PH_3;
          end
          PH_3: begin
            if (pgood) ph_n = PH_4;
            else if (tmr_expired) begin
              if (retry_q) begin
                retry_n = 1'b0; ph_n = PH_0;
              end else begin
                st_n = ST_S5G3; ph_n = PH_0;
              end
            end
          end
          PH_4: begin
            wdg_n = 1'b1;
            ph_n  = PH_5;
          end
          PH_5: begin
            apr_n = 1'b1;
            arm_n = 1'b1;
            tmr_load = 1'b1; tmr_val = CW'(RST_HOLD_MS); ph_n = PH_6;
          end
          PH_6: if (tmr_expired) begin
            st_n = ST_S3; ph_n = PH_0;
          end
          default: ph_n = PH_0;
        endcase
      end

      ST_S3: begin
        if (!pgood || forcing_q) begin
          st_n = ST_S3S5; ph_n = PH_0;
        end else if (!ap_suspend) begin
          st_n = ST_S3S0; ph_n = PH_0;
        end
      end

      ST_S3S0: begin
        if (!pgood) forcing_n = 1'b1;
        st_n = pgood ? ST_S0 : ST_S0S3;
        ph_n = PH_0;
      end

      ST_S0: begin
        if (!pgood || forcing_q || ap_suspend) begin
          st_n = ST_S0S3; ph_n = PH_0;
        end
      end

      ST_S0S3: begin
        st_n = ST_S3; ph_n = PH_0;
      end

      ST_S3S5: begin
        unique case (ph_q)
          PH_0: begin
            if (!pgood) apdown_n = 1'b1;
            arm_n = 1'b0;
            ph_n  = PH_1;
          end
          PH_1: begin
            apr_n = 1'b0;
            ph_n  = PH_2;
          end
          PH_2: begin
            wdg_n = 1'b0;
            tmr_load = 1'b1; tmr_val = CW'(WDOG_HOLD_MS); ph_n = PH_3;
          end
          PH_3: if (tmr_expired) begin
            st_n = ST_S5; ph_n = PH_0;
          end
          default: ph_n = PH_0;
        endcase
      end

      ST_S5G3: begin
        unique case (ph_q)
          PH_0: begin
            if (forcing_q) en_n = 1'b1;
            if (pgood) begin
              frc_n = 1'b0;
              tmr_load = 1'b1; tmr_val = CW'(FORCE_RST_MS); ph_n = PH_1;
            end else begin
              st_n = ST_G3; ph_n = PH_0;
            end
          end
          PH_1: if (tmr_expired) begin
            frc_n = 1'b1;
            ph_n  = PH_0;
          end
          default: ph_n = PH_0;
        endcase
      end

      default: begin
        st_n = ST_G3; ph_n = PH_0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= pgood ? ST_S5 : ST_G3;
      ph_q      <= PH_0;
      en_q      <= 1'b1;
      frc_q     <= 1'b1;
      wdg_q     <= 1'b1;
      apr_q     <= 1'b0;
      arm_q     <= 1'b0;
      forcing_q <= 1'b0;
      retry_q   <= 1'b0;
      apdown_q  <= 1'b0;
      pend_q    <= 1'b0;
      tries_q   <= '0;
    end else begin
      st_q      <= st_n;
      ph_q      <= ph_n;
      en_q      <= en_n;
      frc_q     <= frc_n;
      wdg_q     <= wdg_n;
      apr_q     <= apr_n;
      arm_q     <= arm_n;
      forcing_q <= forcing_n;
      retry_q   <= retry_n;
      apdown_q  <= apdown_n;
      pend_q    <= pend_n;
      tries_q   <= tries_n;
    end
  end

  assign pmic_en_n        = en_q;
  assign pmic_force_rst_n = frc_q;
  assign pmic_wdog_n      = wdg_q;
  assign ap_rst_n         = apr_q;
  assign wd_arm           = arm_q;
  assign state_o          = st_q;

endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
  import pwrseq_pkg::*;
#(
  parameter int PULSE_MS      = 50,
  parameter int PG_TIMEOUT_MS = 300,
  parameter int RST_HOLD_MS   = 2,
  parameter int WDOG_HOLD_MS  = 3,
  parameter int FORCE_RST_MS  = 10000,
  parameter int POLL_MS       = 100,
  parameter int POLL_TRIES    = 40,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       pgood,
  input  logic       ap_suspend,
  input  logic       force_off_req,
  input  logic       power_on_req,
  input  logic       charger_ready,
  input  logic       low_batt,
  input  logic       ap_wdog_n,
  output logic       pmic_en_n,
  output logic       pmic_force_rst_n,
  output logic       pmic_wdog_n,
  output logic       ap_rst_n,
  output logic       wdog_reset_req,
  output logic [3:0] state_o
);

  localparam int MAX_DLY = max2(max2(max2(PULSE_MS, PG_TIMEOUT_MS),
                                     max2(RST_HOLD_MS, WDOG_HOLD_MS)),
                                max2(max2(FORCE_RST_MS, POLL_MS), 1));
  localparam int CW = $clog2(MAX_DLY + 1);

  logic          tmr_load, tmr_expired, wd_arm;
  logic [CW-1:0] tmr_val;

  pwrseq_delay #(.CW(CW)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (ms_tick),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  pwrseq_fsm #(
    .CW            (CW),
    .PULSE_MS      (PULSE_MS),
    .PG_TIMEOUT_MS (PG_TIMEOUT_MS),
    .RST_HOLD_MS   (RST_HOLD_MS),
    .WDOG_HOLD_MS  (WDOG_HOLD_MS),
    .FORCE_RST_MS  (FORCE_RST_MS),
    .POLL_MS       (POLL_MS),
    .POLL_TRIES    (POLL_TRIES)
  ) u_fsm (
    .clk              (clk),
    .rst_n            (rst_n),
    .pgood            (pgood),
    .ap_suspend       (ap_suspend),
    .force_off_req    (force_off_req),
    .power_on_req     (power_on_req),
    .charger_ready    (charger_ready),
    .low_batt         (low_batt),
    .tmr_expired      (tmr_expired),
    .tmr_load         (tmr_load),
    .tmr_val          (tmr_val),
    .pmic_en_n        (pmic_en_n),
    .pmic_force_rst_n (pmic_force_rst_n),
    .pmic_wdog_n      (pmic_wdog_n),
    .ap_rst_n         (ap_rst_n),
    .wd_arm           (wd_arm),
    .state_o          (state_o)
  );

  pwrseq_wdog_filter #(.SYNC_STAGES(SYNC_STAGES)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .wd_in_n (ap_wdog_n),
    .arm     (wd_arm),
    .pgood   (pgood),
    .req     (wdog_reset_req)
  );

endmodule

// File: rtl/pwr_state_seq_chk.sv
module pwr_state_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pgood,
  input logic       pmic_force_rst_n,
  input logic       pmic_wdog_n,
  input logic       ap_rst_n,
  input logic       wdog_reset_req,
  input logic [3:0] state_o
);

  assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 4'd9);

  assert_aprst_rise_in_s5s3_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ap_rst_n) |-> state_o == 4'd5);

  assert_wdog_before_aprst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ap_rst_n |-> pmic_wdog_n);

  assert_s0_from_s3s0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'd3 && $past(state_o) != 4'd3) |-> $past(state_o) == 4'd6);

  assert_frc_only_s5g3_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pmic_force_rst_n) |-> state_o == 4'd9);

  assert_wdreq_needs_pgood_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_reset_req |-> $past(pgood));

endmodule

bind pwr_state_seq pwr_state_seq_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .pgood            (pgood),
  .pmic_force_rst_n (pmic_force_rst_n),
  .pmic_wdog_n      (pmic_wdog_n),
  .ap_rst_n         (ap_rst_n),
  .wdog_reset_req   (wdog_reset_req),
  .state_o          (state_o)
);

// File: tb/tb_pwr_state_seq.sv
module tb_pwr_state_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV  = 4;
  localparam int PULSE = 5;
  localparam int PGTO  = 30;
  localparam int HOLD  = 2;
  localparam int WDH   = 3;
  localparam int FRC   = 40;
  localparam int POLL  = 10;
  localparam int TRIES = 4;

  logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0, pgood = 1'b0, ap_suspend = 1'b1;
  logic force_off_req = 1'b0, power_on_req = 1'b0, charger_ready = 1'b0, low_batt = 1'b0;
  logic ap_wdog_n = 1'b1;
  logic pmic_en_n, pmic_force_rst_n, pmic_wdog_n, ap_rst_n, wdog_reset_req;
  logic [3:0] state_o;

  int checks = 0, errors = 0;
  int tcount = 0, ccount = 0, div = 0;
  int n_en_fall, n_frc_fall, n_wd, n_s5s3;
  int t_en_fall, t_en_rise, t_ap_rise, t_wdg_fall, t_frc_fall, t_frc_rise, t_s3, t_s5;
  int c_ap_fall, c_wdg_fall;
  logic m_en = 1'b1, m_frc = 1'b1, m_wdg = 1'b1, m_ap = 1'b0;
  logic [3:0] m_st = 4'd0;

  pwr_state_seq #(
    .PULSE_MS(PULSE), .PG_TIMEOUT_MS(PGTO), .RST_HOLD_MS(HOLD), .WDOG_HOLD_MS(WDH),
    .FORCE_RST_MS(FRC), .POLL_MS(POLL), .POLL_TRIES(TRIES), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pgood(pgood), .ap_suspend(ap_suspend),
    .force_off_req(force_off_req), .power_on_req(power_on_req),
    .charger_ready(charger_ready), .low_batt(low_batt), .ap_wdog_n(ap_wdog_n),
    .pmic_en_n(pmic_en_n), .pmic_force_rst_n(pmic_force_rst_n), .pmic_wdog_n(pmic_wdog_n),
    .ap_rst_n(ap_rst_n), .wdog_reset_req(wdog_reset_req), .state_o(state_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    div = (div == TDIV-1) ? 0 : div + 1;
    ms_tick = (div == 0);
  end

  // edge and time-stamp monitor, evaluated just after each rising edge
  always @(posedge clk) begin
    #1;
    ccount++;
    if (ms_tick) tcount++;
    if (rst_n) begin
      if (pmic_en_n !== m_en) begin
        if (pmic_en_n === 1'b0) begin n_en_fall++; t_en_fall = tcount; end
        else t_en_rise = tcount;
      end
      if (pmic_force_rst_n !== m_frc) begin
        if (pmic_force_rst_n === 1'b0) begin n_frc_fall++; t_frc_fall = tcount; end
        else t_frc_rise = tcount;
      end
      if (pmic_wdog_n !== m_wdg && pmic_wdog_n === 1'b0) begin
        t_wdg_fall = tcount; c_wdg_fall = ccount;
      end
      if (ap_rst_n !== m_ap) begin
        if (ap_rst_n === 1'b1) t_ap_rise = tcount;
        else c_ap_fall = ccount;
      end
      if (state_o !== m_st) begin
        if (state_o == 4'd2) t_s3 = tcount;
        if (state_o == 4'd1) t_s5 = tcount;
        if (state_o == 4'd5) n_s5s3++;
      end
      if (wdog_reset_req === 1'b1) n_wd++;
    end
    m_en = pmic_en_n; m_frc = pmic_force_rst_n; m_wdg = pmic_wdog_n;
    m_ap = ap_rst_n;  m_st = state_o;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_reset(input logic pg);
    @(negedge clk);
    rst_n = 1'b0; pgood = pg; ap_suspend = 1'b1; force_off_req = 1'b0;
    power_on_req = 1'b0; charger_ready = 1'b0; low_batt = 1'b0; ap_wdog_n = 1'b1;
    repeat (4) @(negedge clk);
    n_en_fall = 0; n_frc_fall = 0; n_wd = 0; n_s5s3 = 0;
    rst_n = 1'b1;
  endtask

  task automatic wait_state(input logic [3:0] code, input int maxc, output bit hit);
    hit = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (state_o == code) begin hit = 1'b1; break; end
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  // power up from G3 to S3; the PMIC model raises pgood during the enable pulse
  task automatic bring_up();
    bit hit;
    do_reset(1'b0);
    charger_ready = 1'b1;
    pulse(power_on_req);
    for (int i = 0; i < 2000 && n_en_fall == 0; i++) @(negedge clk);
    repeat (8) @(negedge clk);
    pgood = 1'b1;
    wait_state(4'd2, 3000, hit);
    chk(hit, "R4", state_o, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit hit;
    int t0, dur, e, k;
    logic [3:0] nxt;

    // R1: reset values for both power-good levels
    for (int pg = 0; pg < 2; pg++) begin
      @(negedge clk);
      rst_n = 1'b0; pgood = pg[0];
      repeat (3) @(negedge clk);
      chk(state_o == (pg ? 4'd1 : 4'd0), "R1", state_o, pg);
      chk({pmic_en_n, pmic_force_rst_n, pmic_wdog_n, ap_rst_n} == 4'b1110, "R1",
          {pmic_en_n, pmic_force_rst_n, pmic_wdog_n, ap_rst_n}, 4'b1110);
    end

    // R11: G3 holds without a request, leaves once one arrives
    do_reset(1'b0);
    repeat (40) @(negedge clk);
    chk(state_o == 4'd0, "R11", state_o, 0);
    pulse(power_on_req);
    wait_state(4'd4, 10, hit);
    chk(hit, "R11", state_o, 4);

    // R2, R4: power-up timing
    bring_up();
    chk(n_en_fall == 1, "R2", n_en_fall, 1);
    chk(t_en_rise - t_en_fall >= PULSE && t_en_rise - t_en_fall <= PULSE + 1, "R2",
        t_en_rise - t_en_fall, PULSE);
    chk(t_s3 - t_ap_rise >= HOLD && t_s3 - t_ap_rise <= HOLD + 1, "R4", t_s3 - t_ap_rise, HOLD);
    chk(pmic_wdog_n && ap_rst_n && pmic_en_n && pmic_force_rst_n, "R4",
        {pmic_en_n, pmic_force_rst_n, pmic_wdog_n, ap_rst_n}, 4'b1111);

    // R5: suspend indicator moves S3 <-> S0
    repeat (20) @(negedge clk);
    chk(state_o == 4'd2, "R5", state_o, 2);
    ap_suspend = 1'b0;
    wait_state(4'd3, 10, hit);
    chk(hit, "R5", state_o, 3);
    ap_suspend = 1'b1;
    wait_state(4'd2, 10, hit);
    chk(hit, "R5", state_o, 2);

    // R10: armed with pgood high gives one pulse
    @(negedge clk); ap_wdog_n = 1'b0;
    repeat (3) @(negedge clk); ap_wdog_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(n_wd == 1, "R10", n_wd, 1);

    // R10 + R6: pgood lost together with a watchdog edge
    @(negedge clk); pgood = 1'b0; ap_wdog_n = 1'b0;
    wait_state(4'd1, 400, hit);
    chk(hit, "R6", state_o, 1);
    chk(n_wd == 1, "R10", n_wd, 1);
    chk(c_ap_fall < c_wdg_fall, "R6", c_ap_fall, c_wdg_fall);
    chk(t_s5 - t_wdg_fall >= WDH && t_s5 - t_wdg_fall <= WDH + 1, "R6", t_s5 - t_wdg_fall, WDH);
    k = n_s5s3;
    wait_state(4'd0, 50, hit);
    chk(hit && n_s5s3 == k, "R6", n_s5s3, k);
    ap_wdog_n = 1'b1;

    // R3: pgood never arrives, two pulses then G3
    do_reset(1'b0);
    charger_ready = 1'b1;
    pulse(power_on_req);
    for (int i = 0; i < 2000 && n_en_fall == 0; i++) @(negedge clk);
    t0 = 0;
    wait_state(4'd9, 3000, hit);
    chk(hit, "R3", state_o, 9);
    chk(n_en_fall == 2, "R3", n_en_fall, 2);
    wait_state(4'd0, 20, hit);
    chk(hit, "R3", state_o, 0);

    // R3: gap between first release and second press
    do_reset(1'b0);
    charger_ready = 1'b1;
    pulse(power_on_req);
    for (int i = 0; i < 2000 && n_en_fall == 0; i++) @(negedge clk);
    for (int i = 0; i < 2000 && pmic_en_n == 1'b0; i++) @(negedge clk);
    t0 = t_en_rise;
    for (int i = 0; i < 2000 && n_en_fall < 2; i++) @(negedge clk);
    dur = t_en_fall - t0;
    chk(dur >= PGTO + PULSE && dur <= PGTO + PULSE + 2, "R3", dur, PGTO + PULSE);

    // R7: forced shutdown from S0 with pgood held high
    bring_up();
    ap_suspend = 1'b0;
    wait_state(4'd3, 20, hit);
    pulse(force_off_req);
    wait_state(4'd1, 400, hit);
    repeat (40) @(negedge clk);
    chk(state_o == 4'd1 && pmic_en_n == 1'b0, "R7", {state_o, pmic_en_n}, 5'b00010);
    chk(ap_rst_n == 1'b0 && pmic_wdog_n == 1'b0, "R6", {ap_rst_n, pmic_wdog_n}, 0);
    // R10: disarmed while the processor is in reset
    k = n_wd;
    @(negedge clk); ap_wdog_n = 1'b0;
    repeat (8) @(negedge clk); ap_wdog_n = 1'b1;
    chk(n_wd == k, "R10", n_wd, k);
    pgood = 1'b0;
    wait_state(4'd0, 50, hit);
    chk(hit && pmic_en_n == 1'b1, "R7", {state_o, pmic_en_n}, 1);

    // R8: pgood in G3 triggers a timed force reset
    do_reset(1'b0);
    repeat (4) @(negedge clk);
    pgood = 1'b1;
    for (int i = 0; i < 100 && n_frc_fall == 0; i++) @(negedge clk);
    chk(state_o == 4'd9 && pmic_force_rst_n == 1'b0, "R8", {state_o, pmic_force_rst_n}, 5'b10010);
    repeat (40) @(negedge clk);
    pgood = 1'b0;
    for (int i = 0; i < 2000 && pmic_force_rst_n == 1'b0; i++) @(negedge clk);
    dur = t_frc_rise - t_frc_fall;
    chk(dur >= FRC && dur <= FRC + 1, "R8", dur, FRC);
    wait_state(4'd0, 20, hit);
    chk(hit && n_frc_fall == 1, "R8", n_frc_fall, 1);

    // R9: sweep of charger arrival poll index and battery flag
    for (int j = 0; j <= TRIES + 1; j++) begin
      for (int lb = 0; lb < 2; lb++) begin
        do_reset(1'b0);
        charger_ready = (j == 0);
        low_batt = lb[0];
        pulse(power_on_req);
        wait_state(4'd4, 20, hit);
        t0 = tcount;
        for (int g = 0; g < 4000 && state_o == 4'd4; g++) begin
          @(negedge clk);
          if (j >= 1 && j <= TRIES && (tcount - t0) >= j * POLL - POLL / 2) charger_ready = 1'b1;
        end
        nxt = state_o;
        dur = tcount - t0;
        k = (j <= TRIES) ? j : TRIES;
        e = k * POLL;
        chk(nxt == ((j <= TRIES && lb == 0) ? 4'd1 : 4'd0), "R9", nxt,
            (j <= TRIES && lb == 0) ? 1 : 0);
        chk(dur >= e && dur <= e + k + 1, "R9", dur, e);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule